// File: doc/BRIEF.md
# Adder with Switching-Activity Energy Monitor

This block is an unsigned adder that also estimates the dynamic energy each addition would cost. Every time the operation strobe is high on a clock edge, the block registers the sum with its carry-out. It counts the bit positions that rose from 0 to 1 since the previous strobed operation, once for the two operands together and once for the result. It turns the two counts into an energy figure using three technology constants: squared supply voltage, input capacitance and output capacitance.

The energy for each operation is presented for one cycle with a valid pulse. It is also added to a running total that saturates instead of wrapping. A synchronous clear returns the operand history, the result history and the total to zero, so the next operation is charged against all-zero history. The block is used in an estimation flow to compare the data-dependent energy of operand streams: the same additions cost different amounts depending on the order in which they arrive.

Top module: `sw_energy_adder`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `sum_out`, `op_energy`, `op_energy_valid` and `energy_total` are all zero.
- R2: When `op_strobe` is high at a clock edge, `sum_out` (WIDTH+1 bits, carry in the top bit) equals `opnd_a + opnd_b` from the following cycle onward.
- R3: The input rise count for an operation is the number of bit positions that are 0 in the previous strobed operand and 1 in the current operand, added together over `opnd_a` and `opnd_b`.
- R4: The output rise count is the number of bits, including the carry bit, that are 0 in the previous `sum_out` and 1 in the new sum.
- R5: `op_energy` = VDD_SQ × (CAP_IN × input rises + CAP_OUT × output rises). It is shown in the cycle after the strobe, with `op_energy_valid` high for exactly that one cycle.
- R6: When `op_strobe` is low, no energy is charged, `op_energy_valid` stays low, and the operand and result history and `energy_total` keep their values.
- R7: `energy_total` increases by each operation's `op_energy` in the same cycle that the energy is shown.
- R8: When an addition would exceed 2^ACC_W − 1, `energy_total` holds at 2^ACC_W − 1.
- R9: `clear` high at a clock edge zeroes the history and `energy_total` and drops `op_energy_valid`. This takes precedence over a strobe in the same cycle.
- R10: The first operation after reset or clear is measured against all-zero operand and result history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_strobe | input | 1 | Perform one addition this cycle |
| clear | input | 1 | Synchronous zeroing of history and total |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| sum_out | output | WIDTH+1 | Registered sum with carry-out |
| op_energy | output | EW | Energy of the last operation (EW derived from the worst case) |
| op_energy_valid | output | 1 | One-cycle pulse marking a new `op_energy` |
| energy_total | output | ACC_W | Saturating running energy total |

## Verification
On every cycle, the assertions check several things. The valid pulse only ever follows a strobe. Without a strobe the result and total do not move. The total never decreases except through clear, and it is zero right after a clear. Each per-operation energy stays at or below the analytic worst case. Only the bench scenarios can show that the counts themselves are right: which bits were counted as rising against which history, the exact weighted energy value, the first operation after clear, and the point at which the total reaches its saturation ceiling.

// File: rtl/adder_energy_pkg.sv
// Shared sizing helpers for the switching-energy adder.
// Assumes all constants are unsigned and small enough for 32-bit math.
package adder_energy_pkg;

    // Bits needed to hold any value 0..v.
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

    // Largest energy one operation can be charged.
    function automatic int unsigned energy_ceiling(
        input int unsigned width, input int unsigned vsq,
        input int unsigned cin, input int unsigned cout);
        return vsq * (cin * 2 * width + cout * (width + 1));
    endfunction

endpackage

// File: rtl/rise_counter.sv
// Counts bit positions going 0 -> 1 between two words using a balanced
// adder tree. Assumes N >= 2. Purely combinational.
module rise_counter #(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = adder_energy_pkg::bits_for(N)
) (
    input  logic [N-1:0]  old_word,
    input  logic [N-1:0]  new_word,
    output logic [CW-1:0] rises
);
    localparam int unsigned LV = $clog2(N);
    localparam int unsigned N2 = 1 << LV;

    logic [N-1:0]  rise_vec;
    logic [CW-1:0] tree [0:LV][0:N2-1];

    // Mark each bit that was low before and is high now.
    assign rise_vec = ~old_word & new_word;

    genvar l, j;
    generate
        for (j = 0; j < N2; j++) begin : g_leaf
            if (j < N) begin : g_bit
                assign tree[0][j] = {{(CW-1){1'b0}}, rise_vec[j]};
            end else begin : g_pad
                assign tree[0][j] = '0;
            end
        end
        for (l = 0; l < LV; l++) begin : g_lvl
            for (j = 0; j < N2; j++) begin : g_node
                if (j < (N2 >> (l + 1))) begin : g_add
                    assign tree[l+1][j] = tree[l][2*j] + tree[l][2*j+1];
                end else begin : g_zero
                    assign tree[l+1][j] = '0;
                end
            end
        end
    endgenerate

    assign rises = tree[LV][0];
endmodule

// File: rtl/energy_calc.sv
// Weighs input and output rise counts by technology constants:
// energy = VDD_SQ * (CAP_IN * n_in + CAP_OUT * n_out). Combinational.
// Assumes EW is wide enough for the worst case (caller derives it).
module energy_calc #(
    parameter int unsigned IN_W    = 5,
    parameter int unsigned OUT_W   = 4,
    parameter int unsigned EW      = 9,
    parameter int unsigned VDD_SQ  = 5,
    parameter int unsigned CAP_IN  = 2,
    parameter int unsigned CAP_OUT = 3
) (
    input  logic [IN_W-1:0]  n_in,
    input  logic [OUT_W-1:0] n_out,
    output logic [EW-1:0]    energy
);
    logic [EW-1:0] weighted;

    // Capacitance-weighted sum of the two transition counts.
    always_comb begin
        weighted = EW'(CAP_IN) * EW'(n_in) + EW'(CAP_OUT) * EW'(n_out);
        energy   = EW'(VDD_SQ) * weighted;
    end
endmodule

// File: rtl/sat_accum.sv
// Running total with saturation at all-ones and a synchronous clear.
// Assumes ACC_W >= EW.
module sat_accum #(
    parameter int unsigned EW    = 9,
    parameter int unsigned ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [EW-1:0]    addend,
    output logic [ACC_W-1:0] total
);
    logic [ACC_W:0] wide_sum;

    // One extra bit exposes overflow of the addition.
    assign wide_sum = {1'b0, total} + {{(ACC_W+1-EW){1'b0}}, addend};

    // Clear, accumulate, or pin at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)    total <= '0;
        else if (add_en) begin
            if (wide_sum[ACC_W]) total <= '1;
            else                 total <= wide_sum[ACC_W-1:0];
        end
    end

    // The total only ever shrinks through clear.
    assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> total >= $past(total));
    // A clear leaves a zero total behind.
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> total == '0);
endmodule

// File: rtl/sw_energy_adder.sv
// Adder that charges each strobed operation a dynamic-energy estimate
// from 0->1 transitions on both operands and on the sum (carry included).
// History updates only on strobe; clear beats strobe. Sync active-low reset.
module sw_energy_adder #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned VDD_SQ  = 5,
    parameter int unsigned CAP_IN  = 2,
    parameter int unsigned CAP_OUT = 3,
    parameter int unsigned ACC_W   = 24,
    localparam int unsigned SW     = WIDTH + 1,
    localparam int unsigned EMAX   =
        adder_energy_pkg::energy_ceiling(WIDTH, VDD_SQ, CAP_IN, CAP_OUT),
    localparam int unsigned EW     = adder_energy_pkg::bits_for(EMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_strobe,
    input  logic             clear,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [SW-1:0]    sum_out,
    output logic [EW-1:0]    op_energy,
    output logic             op_energy_valid,
    output logic [ACC_W-1:0] energy_total
);
    localparam int unsigned OPC_W = adder_energy_pkg::bits_for(WIDTH);
    localparam int unsigned INC_W = adder_energy_pkg::bits_for(2 * WIDTH);
    localparam int unsigned OUTC_W = adder_energy_pkg::bits_for(SW);

    logic [WIDTH-1:0]  prev_a, prev_b;
    logic [SW-1:0]     next_sum;
    logic [OPC_W-1:0]  rise_a, rise_b;
    logic [OUTC_W-1:0] rise_s;
    logic [INC_W-1:0]  rise_in;
    logic [EW-1:0]     energy_now;
    logic              take_op;

    // An operation happens on strobe unless clear overrides it.
    assign take_op  = op_strobe && !clear;
    assign next_sum = SW'(opnd_a) + SW'(opnd_b);
    assign rise_in  = INC_W'(rise_a) + INC_W'(rise_b);

    rise_counter #(.N(WIDTH)) u_rise_a (
        .old_word(prev_a), .new_word(opnd_a), .rises(rise_a));
    rise_counter #(.N(WIDTH)) u_rise_b (
        .old_word(prev_b), .new_word(opnd_b), .rises(rise_b));
    rise_counter #(.N(SW)) u_rise_s (
        .old_word(sum_out), .new_word(next_sum), .rises(rise_s));

    energy_calc #(
        .IN_W(INC_W), .OUT_W(OUTC_W), .EW(EW),
        .VDD_SQ(VDD_SQ), .CAP_IN(CAP_IN), .CAP_OUT(CAP_OUT)
    ) u_energy (
        .n_in(rise_in), .n_out(rise_s), .energy(energy_now));

    // History, result and per-operation energy registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_a          <= '0;
            prev_b          <= '0;
            sum_out         <= '0;
            op_energy       <= '0;
            op_energy_valid <= 1'b0;
        end else if (take_op) begin
            prev_a          <= opnd_a;
            prev_b          <= opnd_b;
            sum_out         <= next_sum;
            op_energy       <= energy_now;
            op_energy_valid <= 1'b1;
        end else begin
            op_energy_valid <= 1'b0;
        end
    end

    sat_accum #(.EW(EW), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(clear), .add_en(take_op),
        .addend(energy_now), .total(energy_total));

    // A valid pulse only follows an accepted strobe.
    assert_valid_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_energy_valid |-> $past(op_strobe && !clear));
    // Idle cycles leave result and total untouched.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_strobe && !clear) |=> ($stable(sum_out) && $stable(energy_total)
                                    && !op_energy_valid));
    // Per-operation energy never exceeds the analytic ceiling.
    assert_energy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_energy <= EW'(EMAX));
    // Total grows by exactly the shown energy unless it saturates.
    assert_accumulate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_energy_valid && energy_total != '1) |->
            energy_total == $past(energy_total) + ACC_W'(op_energy));
endmodule

// File: tb/sw_energy_adder_test.sv
module sw_energy_adder_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int ACCW = 10;
    localparam int SATMAX = (1 << ACCW) - 1;
    localparam logic [15:0] VECS [8] = '{
        16'h0102, 16'hFF01, 16'h0000, 16'h0FF0,
        16'hFFFF, 16'h8080, 16'h55AA, 16'h1234};

    logic clk = 1'b0, rst_n = 1'b0, op_strobe = 1'b0, clear = 1'b0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic [W:0] sum_out;
    logic [8:0] op_energy;
    logic op_energy_valid;
    logic [ACCW-1:0] energy_total;

    int n_checks = 0, n_fail = 0;
    int ha = 0, hb = 0, hs = 0, tot = 0;
    bit done = 0;

    sw_energy_adder #(.WIDTH(W), .VDD_SQ(5), .CAP_IN(2), .CAP_OUT(3), .ACC_W(ACCW)) uut (
        .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .clear(clear),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sum_out(sum_out), .op_energy(op_energy),
        .op_energy_valid(op_energy_valid), .energy_total(energy_total));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rises(input int oldv, input int newv);
        int c = 0;
        for (int i = 0; i < 16; i++) if (!oldv[i] && newv[i]) c++;
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobed operation, checked against the bench model.
    task automatic do_op(input int a, input int b);
        int s, e;
        @(negedge clk);
        opnd_a = W'(a); opnd_b = W'(b); op_strobe = 1'b1;
        @(negedge clk);
        op_strobe = 1'b0;
        s = a + b;
        e = 5 * (2 * (rises(ha, a) + rises(hb, b)) + 3 * rises(hs, s));
        tot = (tot + e > SATMAX) ? SATMAX : tot + e;
        ha = a; hb = b; hs = s;
        chk("R2 sum", int'(sum_out), s);
        chk("R3 R4 R5 energy", int'(op_energy), e);
        chk("R5 valid", int'(op_energy_valid), 1);
        chk("R7 R8 total", int'(energy_total), tot);
        @(negedge clk);
        chk("R5 pulse one cycle", int'(op_energy_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sum in reset", int'(sum_out), 0);
        chk("R1 total in reset", int'(energy_total), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(op_energy_valid), 0);
        chk("R1 energy after reset", int'(op_energy), 0);

        // Table walk; the first entry exercises R10 against zero history.
        for (int i = 0; i < 8; i++) do_op(int'(VECS[i][15:8]), int'(VECS[i][7:0]));

        // R6: operands move without strobe; nothing changes.
        clear = 1'b0;
        @(negedge clk); opnd_a = 8'hF0; opnd_b = 8'h0F;
        repeat (3) @(negedge clk);
        chk("R6 valid idle", int'(op_energy_valid), 0);
        chk("R6 total idle", int'(energy_total), tot);
        chk("R6 sum idle", int'(sum_out), hs);
        do_op(8'hF0, 8'h0F);

        // R9: clear together with strobe; clear wins.
        @(negedge clk);
        clear = 1'b1; op_strobe = 1'b1; opnd_a = 8'h33; opnd_b = 8'h44;
        @(negedge clk);
        clear = 1'b0; op_strobe = 1'b0;
        ha = 0; hb = 0; hs = 0; tot = 0;
        chk("R9 total cleared", int'(energy_total), 0);
        chk("R9 sum cleared", int'(sum_out), 0);
        chk("R9 no valid", int'(op_energy_valid), 0);
        do_op(8'h01, 8'h01); // R10: compared with zero history after clear

        // R8: drive the total into saturation and keep it there.
        for (int k = 0; k < 5; k++) begin
            do_op(8'hFF, 8'hFF);
            do_op(8'h00, 8'h00);
        end
        chk("R8 saturated", int'(energy_total), SATMAX);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule